// File: doc/BRIEF.md
# Parallel Configuration Load Master

This block is a hardware sequencer that writes a configuration bitstream into a programmable target device through a byte-wide slave parallel port. A host gives it a start pulse and a total byte count. The bytes then arrive on a valid/ready stream. The block drives the target's reset (program) line, chip select, write strobe, configuration clock and 8-bit data bus. It samples the target's init, busy and done indications.

A load runs through five steps in order:
1. A reset pulse on the program line.
2. A guarded wait until the target reports that it is ready.
3. A byte transfer phase. Each byte is set up on the bus before the clock falls, and the target latches it on the next rising clock edge.
4. Extra clock cycles while the target reports busy.
5. Trailing clocks with chip select and write released, until done appears.

Each waiting step has its own timeout, derived from the system clock frequency. A timeout ends the load with a sticky error flag and a single-cycle abort pulse. A load that completes sets a sticky done flag. Both flags stay set until the next accepted start.

Top module: `cfg_load_master`

## Requirements
- R1: After reset, every target control pin, the data bus, `s_ready_o`, `busy_o`, `done_o`, `error_o` and `abort_o` are low.
- R2: A start accepted while idle latches `len_i` and raises `tgt_prog_o` for exactly `PROG_CYC` cycles. A start while `busy_o` is high is ignored, and the running load keeps its original length.
- R3: After the program pulse, the block waits until `tgt_init_i` is 1 and `tgt_busy_i` is 0. If that does not happen within the timeout window of `CLK_FREQ_HZ/1000*TIMEOUT_MS` cycles, `error_o` sets and `abort_o` pulses for exactly one cycle.
- R4: The target receives exactly `len_i` bytes in stream order. Each byte is latched on a rising `tgt_cclk_o` while `tgt_cs_o` and `tgt_wr_o` are both 1. `tgt_data_o` changes only while `tgt_cclk_o` is high, which is before the clock falls.
- R5: During a load, every high and low phase of `tgt_cclk_o` lasts at least the number of system cycles needed to keep it at or below `CCLK_MAX_HZ`.
- R6: When `CHECK_BUSY` is 1 and `tgt_busy_i` is 1 at the end of a clock-high phase, the block gives another full clock cycle without taking a new byte. It repeats this until busy drops. If busy lasts longer than the timeout window, the load aborts.
- R7: After the last byte, `tgt_cs_o` falls at least one cycle before `tgt_wr_o`.
- R8: After write is released, `tgt_cclk_o` keeps toggling until `tgt_done_i` is seen, and then `done_o` sets. If done does not appear within the timeout window, the load aborts with `error_o`.
- R9: `busy_o` is high for the whole load. `done_o` and `error_o` are never both 1. They stay set while idle and clear on the next accepted start.
- R10: A byte count of 0 skips the data phase: no clock rises while chip select is active, and the load still finishes through the done phase.
- R11: `s_ready_o` is high only in the data phase, so the stream gives up exactly `len_i` bytes per load, even when more are offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (sampled while idle) |
| len_i | input | CNT_W | Number of bytes in the load |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte accepted when high with valid |
| tgt_prog_o | output | 1 | Target reset request, active high |
| tgt_cs_o | output | 1 | Target chip select, active high |
| tgt_wr_o | output | 1 | Target write strobe, active high |
| tgt_cclk_o | output | 1 | Target configuration clock |
| tgt_data_o | output | 8 | Target data bus |
| tgt_init_i | input | 1 | Target init indication, 1 = initialised |
| tgt_busy_i | input | 1 | Target busy indication, 1 = busy |
| tgt_done_i | input | 1 | Target done indication, 1 = configured |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Sticky: last load completed |
| error_o | output | 1 | Sticky: last load timed out |
| abort_o | output | 1 | One-cycle pulse when a load fails |

## Verification
The bench sets `CLK_FREQ_HZ` to 20000 and `CCLK_MAX_HZ` to 5000, with a 10 ms timeout. This gives a two-cycle clock half period and a 200-cycle timeout window. All three timeout paths can then be reached in a few hundred cycles, and the two-cycle half period tests the phase counter's wrap. A `PROG_CYC` of 4 keeps the reset pulse short enough to measure exactly. An 8-bit count leaves room for the ignored-start case to request a length that differs from the running one. A target model in the bench answers with random busy stalls of one to three clocks and random numbers of trailing clocks, so the stall loop and the done loop both run for different lengths.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT,
    ST_SETUP,
    ST_FETCH,
    ST_PUT,
    ST_LOW,
    ST_HIGH,
    ST_CS_OFF,
    ST_WR_OFF,
    ST_DCLK,
    ST_OK,
    ST_FAIL
  } ld_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == LAST);

  // Clears while disabled, wraps on hit so it can also act as a phase divider.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (hit_o)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_pin_drv.sv
module cfg_pin_drv
  import cfg_load_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ld_state_e state_q_i,
  input  ld_state_e state_d_i,
  input  logic      tick_i,
  output logic      prog_o,
  output logic      cs_o,
  output logic      wr_o,
  output logic      cclk_o,
  output logic      abort_o,
  output logic      busy_o
);
  logic prog_d, cs_d, wr_d, cclk_d, abort_d, busy_d;

  always_comb begin
    prog_d  = (state_d_i == ST_PROG);
    cs_d    = state_d_i inside {ST_SETUP, ST_FETCH, ST_PUT, ST_LOW, ST_HIGH};
    wr_d    = cs_d || (state_d_i == ST_CS_OFF);
    abort_d = (state_d_i == ST_FAIL);
    busy_d  = (state_d_i != ST_IDLE);
    unique case (state_d_i)
      ST_IDLE, ST_FAIL, ST_LOW: cclk_d = 1'b0;
      ST_OK:                    cclk_d = cclk_o;
      ST_DCLK: begin
        if (state_q_i != ST_DCLK) cclk_d = 1'b1;
        else if (tick_i)          cclk_d = ~cclk_o;
        else                      cclk_d = cclk_o;
      end
      default:                  cclk_d = 1'b1;
    endcase
  end

  // All target pins leave a flop so they never glitch on state decode.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_o  <= 1'b0;
      cs_o    <= 1'b0;
      wr_o    <= 1'b0;
      cclk_o  <= 1'b0;
      abort_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      prog_o  <= prog_d;
      cs_o    <= cs_d;
      wr_o    <= wr_d;
      cclk_o  <= cclk_d;
      abort_o <= abort_d;
      busy_o  <= busy_d;
    end
  end
endmodule

// File: rtl/cfg_load_master.sv
module cfg_load_master
  import cfg_load_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned CCLK_MAX_HZ = 50_000_000,
  parameter int unsigned TIMEOUT_MS  = 10,
  parameter int unsigned PROG_CYC    = 64,
  parameter int unsigned CNT_W       = 24,
  parameter bit          CHECK_BUSY  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  output logic             tgt_prog_o,
  output logic             tgt_cs_o,
  output logic             tgt_wr_o,
  output logic             tgt_cclk_o,
  output logic [7:0]       tgt_data_o,
  input  logic             tgt_init_i,
  input  logic             tgt_busy_i,
  input  logic             tgt_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             error_o,
  output logic             abort_o
);
  localparam int unsigned HALF_RAW = ceil_div(CLK_FREQ_HZ, 2 * CCLK_MAX_HZ);
  localparam int unsigned HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned TMO_RAW  = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS;
  localparam int unsigned TMO_CYC  = (TMO_RAW < 1) ? 1 : TMO_RAW;
  localparam int unsigned PRG_CYC  = (PROG_CYC < 1) ? 1 : PROG_CYC;

  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] rem_q;
  logic [7:0]       data_q;
  logic             stall_q, done_q, error_q;
  logic             prog_hit, half_tick, tmo_hit;
  logic             prog_en, half_en, wait_en;
  logic             take;

  assign prog_en = (state_q == ST_PROG);
  assign half_en = state_q inside {ST_PUT, ST_LOW, ST_HIGH, ST_DCLK};
  assign wait_en = (state_q == ST_WAIT) || (state_q == ST_DCLK) ||
                   (stall_q && (state_q inside {ST_LOW, ST_HIGH}));

  cfg_cycle_timer #(.LIMIT(PRG_CYC)) i_prog_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(prog_en), .hit_o(prog_hit));

  cfg_cycle_timer #(.LIMIT(HALF_CYC)) i_half_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(half_en), .hit_o(half_tick));

  cfg_cycle_timer #(.LIMIT(TMO_CYC)) i_wait_tmr (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(wait_en), .hit_o(tmo_hit));

  assign s_ready_o = (state_q == ST_FETCH);
  assign take      = s_ready_o && s_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_PROG;
      ST_PROG:   if (prog_hit) state_d = ST_WAIT;
      ST_WAIT: begin
        if (tgt_init_i && !tgt_busy_i) state_d = ST_SETUP;
        else if (tmo_hit)              state_d = ST_FAIL;
      end
      ST_SETUP:  state_d = (rem_q == '0) ? ST_CS_OFF : ST_FETCH;
      ST_FETCH:  if (s_valid_i) state_d = ST_PUT;
      ST_PUT:    if (half_tick) state_d = ST_LOW;
      ST_LOW: begin
        if (tmo_hit)        state_d = ST_FAIL;
        else if (half_tick) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (tmo_hit) state_d = ST_FAIL;
        else if (half_tick) begin
          if (CHECK_BUSY && tgt_busy_i) state_d = ST_LOW;
          else if (rem_q == '0)         state_d = ST_CS_OFF;
          else                          state_d = ST_FETCH;
        end
      end
      ST_CS_OFF: state_d = ST_WR_OFF;
      ST_WR_OFF: state_d = ST_DCLK;
      ST_DCLK: begin
        if (tgt_done_i)   state_d = ST_OK;
        else if (tmo_hit) state_d = ST_FAIL;
      end
      ST_OK, ST_FAIL: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      data_q  <= '0;
      stall_q <= 1'b0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        rem_q   <= len_i;
        done_q  <= 1'b0;
        error_q <= 1'b0;
      end else if (take) begin
        rem_q  <= rem_q - 1'b1;
        data_q <= s_data_i;
      end
      if (state_q == ST_HIGH && half_tick) stall_q <= CHECK_BUSY && tgt_busy_i;
      else if (state_q == ST_IDLE)         stall_q <= 1'b0;
      if (state_d == ST_OK)   done_q  <= 1'b1;
      if (state_d == ST_FAIL) error_q <= 1'b1;
    end
  end

  assign tgt_data_o = data_q;
  assign done_o     = done_q;
  assign error_o    = error_q;

  cfg_pin_drv i_pin_drv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_q_i(state_q),
    .state_d_i(state_d),
    .tick_i   (half_tick),
    .prog_o   (tgt_prog_o),
    .cs_o     (tgt_cs_o),
    .wr_o     (tgt_wr_o),
    .cclk_o   (tgt_cclk_o),
    .abort_o  (abort_o),
    .busy_o   (busy_o)
  );
endmodule

// File: rtl/cfg_load_master_chk.sv
module cfg_load_master_chk #(
  parameter int unsigned HALF_CYC = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       s_ready_o,
  input logic       tgt_prog_o,
  input logic       tgt_cs_o,
  input logic       tgt_wr_o,
  input logic       tgt_cclk_o,
  input logic [7:0] tgt_data_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o,
  input logic       abort_o
);
  localparam int unsigned RW = $clog2(HALF_CYC + 2);

  logic [RW-1:0] run_q;
  logic          cclk_prev, busy_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= '0;
      cclk_prev <= 1'b0;
      busy_prev <= 1'b0;
    end else begin
      cclk_prev <= tgt_cclk_o;
      busy_prev <= busy_o;
      if (tgt_cclk_o != cclk_prev)       run_q <= RW'(1);
      else if (run_q != RW'(HALF_CYC))   run_q <= run_q + 1'b1;
    end
  end

  p_prog_in_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_prog_o |-> busy_o && !tgt_cs_o && !tgt_wr_o);

  p_abort_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  p_abort_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> error_o && !done_o);

  p_data_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tgt_data_o) |-> tgt_cclk_o && $past(tgt_cclk_o));

  p_cclk_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_cclk_o != cclk_prev) && busy_o && busy_prev && !abort_o |-> run_q >= RW'(HALF_CYC));

  p_cs_before_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tgt_wr_o) && !abort_o |-> !$past(tgt_cs_o));

  p_done_idle_pins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tgt_cs_o && !tgt_wr_o && !tgt_prog_o);

  p_flags_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));

  p_ready_window_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> tgt_cs_o && tgt_wr_o && tgt_cclk_o && busy_o);
endmodule

bind cfg_load_master cfg_load_master_chk #(.HALF_CYC(HALF_CYC)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .s_ready_o (s_ready_o),
  .tgt_prog_o(tgt_prog_o),
  .tgt_cs_o  (tgt_cs_o),
  .tgt_wr_o  (tgt_wr_o),
  .tgt_cclk_o(tgt_cclk_o),
  .tgt_data_o(tgt_data_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .error_o   (error_o),
  .abort_o   (abort_o)
);

// File: tb/test_cfg_load_master.sv
module test_cfg_load_master;
  localparam int CLK_HZ   = 20000;
  localparam int CCLK_HZ  = 5000;
  localparam int TMO_MS   = 10;
  localparam int PROG_CYC = 4;
  localparam int CNT_W    = 8;
  localparam int TMO      = CLK_HZ / 1000 * TMO_MS;
  localparam int INIT_DLY = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] len = '0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, s_ready;
  logic prog, cs, wr, cclk, busy, done, error, abort;
  logic [7:0] tdata;
  logic init_i = 1'b1, tbusy_i = 1'b0, tdone_i = 1'b0;

  always #4 clk = ~clk;

  cfg_load_master #(
    .CLK_FREQ_HZ(CLK_HZ), .CCLK_MAX_HZ(CCLK_HZ), .TIMEOUT_MS(TMO_MS),
    .PROG_CYC(PROG_CYC), .CNT_W(CNT_W), .CHECK_BUSY(1'b1)
  ) i_cfg_load_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_ready_o(s_ready),
    .tgt_prog_o(prog), .tgt_cs_o(cs), .tgt_wr_o(wr), .tgt_cclk_o(cclk),
    .tgt_data_o(tdata), .tgt_init_i(init_i), .tgt_busy_i(tbusy_i),
    .tgt_done_i(tdone_i), .busy_o(busy), .done_o(done), .error_o(error),
    .abort_o(abort)
  );

  int checks = 0, fails = 0, cyc = 0;

  // stimulus / model state
  logic [7:0] src [0:79];
  logic [7:0] cap [0:63];
  bit busy_mark [0:63];
  bit src_on = 0, take_pend = 0, init_never = 0, busy_forever = 0;
  int sent = 0, busy_len = 1, done_after = 0, init_cnt = 0, brc = 0;
  int ncap = 0, data_rises = 0, dclk_rises = 0, abort_cnt = 0, prog_w = 0;
  int wait_cyc = 0, tmo_elapsed = 0;
  bit done_arm = 0, wr_at_cs_fall = 0, wait_on = 0;
  logic prev_cclk = 0, prev_cs = 0, prev_wr = 0, prev_prog = 0, prev_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // stream source
  always @(negedge clk) begin
    if (!src_on) begin
      s_valid = 1'b0; take_pend = 0;
    end else begin
      if (take_pend) begin
        sent++;
        s_valid = ($urandom_range(0, 3) != 0);
      end else if (!s_valid) s_valid = 1'b1;
      s_data = src[sent];
      take_pend = s_valid && s_ready;
    end
  end

  // target model and monitor
  always @(negedge clk) if (rst_n) begin
    if (prog) begin
      init_i = 1'b0; init_cnt = 0; tdone_i = 1'b0; done_arm = 0;
    end else if (!init_i && !init_never) begin
      if (init_cnt == INIT_DLY - 1) init_i = 1'b1;
      else init_cnt++;
    end
    if (cclk && !prev_cclk) begin
      if (cs && wr) begin
        data_rises++;
        if (tbusy_i) begin
          brc++;
          if (!busy_forever && brc >= busy_len) tbusy_i = 1'b0;
        end else if (ncap < 64) begin
          cap[ncap] = tdata;
          if (busy_mark[ncap]) begin tbusy_i = 1'b1; brc = 0; end
          ncap++;
        end
      end else if (done_arm) begin
        dclk_rises++;
        if (done_after >= 0 && dclk_rises >= done_after) tdone_i = 1'b1;
      end
    end
    if (prev_cs && !cs) wr_at_cs_fall = wr;
    if (prev_wr && !wr && !abort) begin
      done_arm = 1;
      if (done_after == 0) tdone_i = 1'b1;
    end
    if (abort) abort_cnt++;
    if (prog) prog_w++;
    if (prev_prog && !prog) begin wait_on = 1; wait_cyc = 0; end
    if (wait_on) wait_cyc++;
    if (error && !prev_err && wait_on) begin tmo_elapsed = wait_cyc; wait_on = 0; end
    if (!error && !prev_err && (init_i && !prog)) wait_on = wait_on && init_never;
    prev_cclk = cclk; prev_cs = cs; prev_wr = wr; prev_prog = prog; prev_err = error;
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic prepare(input int blen, input int dafter);
    for (int i = 0; i < 64; i++) busy_mark[i] = 0;
    for (int i = 0; i < 80; i++) src[i] = 8'($urandom);
    busy_len = blen; done_after = dafter; busy_forever = 0; init_never = 0;
    tbusy_i = 1'b0; brc = 0; ncap = 0; data_rises = 0; dclk_rises = 0;
    abort_cnt = 0; prog_w = 0; wr_at_cs_fall = 0; tmo_elapsed = 0; wait_on = 0;
    sent = 0;
  endtask

  task automatic launch(input int n);
    len = CNT_W'(n);
    src_on = 1;
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R9 busy after start", int'(busy), 1);
    chk("R9 status cleared on start", int'(done) + int'(error), 0);
  endtask

  task automatic finish_load();
    int guard = 0;
    while (busy && guard < 4000) begin step(); guard++; end
    chk("R9 load terminates", int'(busy), 0);
    step();
    src_on = 0;
    step();
  endtask

  function automatic int exp_rises(input int n, input int blen);
    int r = n;
    for (int i = 0; i < n; i++) if (busy_mark[i]) r += blen;
    return r;
  endfunction

  task automatic check_good(input int n, input int blen);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] !== src[i]) bad++;
    chk("R4 byte count", ncap, n);
    chk("R4 byte order/content mismatches", bad, 0);
    chk("R6 clocks incl. stalls", data_rises, exp_rises(n, blen));
    chk("R11 stream bytes taken", sent, n);
    chk("R7 wr still high at cs fall", int'(wr_at_cs_fall), 1);
    chk("R2 program pulse width", prog_w, PROG_CYC);
    chk("R8 done set", int'(done), 1);
    chk("R8 no error", int'(error), 0);
    chk("R3 no abort", abort_cnt, 0);
    chk("R8 trailing clocks reached", int'(dclk_rises >= done_after), 1);
  endtask

  initial begin
    void'($urandom(32'h1c0f_ab57));
    for (int i = 0; i < 64; i++) busy_mark[i] = 0;
    step(2);
    // R1 reset state
    chk("R1 pins in reset", int'({prog, cs, wr, cclk}), 0);
    chk("R1 data in reset", int'(tdata), 0);
    chk("R1 status in reset", int'({s_ready, busy, done, error, abort}), 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 idle after reset", int'({prog, cs, wr, s_ready, busy, abort}), 0);

    // directed: short load, no stalls
    prepare(1, 3);
    launch(4);
    finish_load();
    check_good(4, 1);
    step(10);
    chk("R9 done sticky while idle", int'(done), 1);

    // directed: busy on first and last byte
    prepare(2, 1);
    busy_mark[0] = 1; busy_mark[4] = 1;
    launch(5);
    finish_load();
    check_good(5, 2);

    // R2: start during a load is ignored
    prepare(1, 2);
    launch(6);
    step(20);
    len = CNT_W'(30);
    start = 1'b1; step(); start = 1'b0;
    finish_load();
    check_good(6, 1);

    // R10: zero-length load
    prepare(1, 2);
    launch(0);
    finish_load();
    chk("R10 no data clocks", data_rises, 0);
    chk("R10 no bytes taken", sent, 0);
    chk("R10 done set", int'(done), 1);

    // random loads
    for (int t = 0; t < 10; t++) begin
      int n, bl;
      n = $urandom_range(1, 16);
      bl = $urandom_range(1, 3);
      prepare(bl, $urandom_range(0, 4));
      for (int i = 0; i < n; i++) busy_mark[i] = ($urandom_range(0, 3) == 0);
      launch(n);
      finish_load();
      check_good(n, bl);
    end

    // R3: init never comes
    prepare(1, 1);
    init_never = 1;
    launch(3);
    finish_load();
    chk("R3 error on ready timeout", int'(error), 1);
    chk("R3 no done", int'(done), 0);
    chk("R3 single abort", abort_cnt, 1);
    chk("R3 timeout window", int'(tmo_elapsed >= TMO && tmo_elapsed <= TMO + 2), 1);
    chk("R3 no bytes sent", ncap, 0);

    // R6: busy never clears
    prepare(1, 1);
    busy_mark[1] = 1; busy_forever = 1;
    launch(5);
    finish_load();
    chk("R6 error on stall timeout", int'(error), 1);
    chk("R6 bytes before stall", ncap, 2);
    chk("R6 single abort", abort_cnt, 1);
    tbusy_i = 1'b0;

    // R8: done never comes
    prepare(1, -1);
    launch(3);
    finish_load();
    chk("R8 error on done timeout", int'(error), 1);
    chk("R8 all bytes before timeout", ncap, 3);
    chk("R8 single abort", abort_cnt, 1);
    chk("R8 trailing clocks given", int'(dclk_rises > 1), 1);

    // R9: error cleared by next good load
    prepare(1, 0);
    launch(2);
    finish_load();
    check_good(2, 1);

    summary();
    $finish;
  end
endmodule